// File: doc/BRIEF.md
# Bus Source Handshake Engine with Settling Delay

This block is the sending half of a parallel instrument bus port. A processor loads one byte at a time into a write-only output holding register. The engine then places the byte on the eight data lines and waits a settling time before it raises the data-valid strobe. The receivers pace the transfer with the ready-for-data and data-accepted lines. The same engine sends interface commands while this port is the active controller and holds attention true. It sends device data while attention is false and the port is addressed to talk.

A status flag tells the processor when the holding register can take the next byte. The settling time is 11 or 6 clocks, chosen by a static auxiliary command. A pulsed auxiliary command marks the next byte as the last of a message by driving end-or-identify with it.

If a foreign controller raises attention after a byte is loaded, the byte waits and is sent once attention drops. A second pulsed command can cancel that stalled byte. If no acceptor is present at the end of the settling time, the engine drops the transfer and pulses an error.

Top module: `srchs_engine`

## Requirements
- R1: After reset `bo_empty` is 0. It becomes 1 one cycle after `src_active` rises, and in the same cycle that `dav_out` falls at the end of a completed transfer.
- R2: A `dout_wr` pulse is accepted only when no byte is pending. An accepted write clears `bo_empty` on the next cycle. A write made while a byte is pending is ignored, and the pending byte is the one sent.
- R3: Auxiliary codes use bit 7 as set/clear and bits 4:0 as the function. A code with bits 6:5 not zero is ignored. Function 0x15 with bit 7 set (0x95) selects a 6-clock settling time, and with bit 7 clear (0x15) selects the 11-clock default. `dav_out` rises T1+1 cycles after the cycle in which sending became possible, whether that cycle was an accepted write or an attention release.
- R4: `dio_out` carries the loaded byte from the start of the settling time until `dav_out` falls, and does not change while `dav_out` is high.
- R5: `dav_out` rises only if `nrfd_in` was false in the previous cycle. While `nrfd_in` stays true after the settling time, `dav_out` stays low.
- R6: `dav_out` falls in the cycle after `ndac_in` is seen false. A new byte does not start until `ndac_in` has returned true.
- R7: Pulsed code 0x08 makes `eoi_out` high throughout the settling and valid phases of the next byte sent. `eoi_out` stays low for the bytes after it.
- R8: A byte may start only when `ctl_atn` is 1 or `bus_atn` is 0. A byte stalled by `bus_atn` is sent when `bus_atn` falls. If `bus_atn` rises during the settling time, the settling time restarts after it falls.
- R9: Pulsed code 0x05, issued while a byte is stalled, discards that byte and sets `bo_empty`. No transfer follows.
- R10: If `nrfd_in` and `ndac_in` are both false at the end of the settling time, `hs_err` pulses for one cycle T1+1 cycles after the write. `dav_out` stays low, the byte is discarded and `bo_empty` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_active | input | 1 | Port is addressed to talk or is the active controller |
| ctl_atn | input | 1 | This port drives attention (command mode) |
| bus_atn | input | 1 | Sampled attention line of the bus |
| nrfd_in | input | 1 | Not-ready-for-data, true high |
| ndac_in | input | 1 | Not-data-accepted, true high |
| dout_wr | input | 1 | Write strobe of the output holding register |
| dout_data | input | 8 | Byte to send |
| aux_wr | input | 1 | Auxiliary command strobe |
| aux_code | input | 8 | Auxiliary command code |
| dio_out | output | 8 | Data lines |
| dav_out | output | 1 | Data valid, true high |
| eoi_out | output | 1 | End-or-identify, true high |
| bo_empty | output | 1 | Holding register may be written |
| hs_err | output | 1 | One-cycle pulse on an incomplete source handshake |

## Verification
The bench builds the block with its default settling times of 11 and 6 clocks and an 8-bit data path. With these values both settling lengths can be measured to the exact cycle within one short run, including a switch between them on consecutive bytes. The small values also leave room for long foreign-attention stalls, a held ready line, a slow data-accepted rearm and random acceptor delays. These cases cover the restart of the settling time and the missing-acceptor abort.

// File: rtl/srchs_pkg.sv
package srchs_pkg;
  typedef enum logic [1:0] {
    SH_IDLE    = 2'd0,
    SH_SETTLE  = 2'd1,
    SH_VALID   = 2'd2,
    SH_RELEASE = 2'd3
  } sh_state_e;

  localparam logic [4:0] FN_NBAF  = 5'h05;
  localparam logic [4:0] FN_FEOI  = 5'h08;
  localparam logic [4:0] FN_T1SEL = 5'h15;
endpackage

// File: rtl/srchs_aux_decode.sv
module srchs_aux_decode
  import srchs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       aux_wr,
  input  logic [7:0] aux_code,
  output logic       t1_short,
  output logic       feoi_p,
  output logic       nbaf_p
);
  logic       code_ok;
  logic [4:0] fn;
  logic       t1_short_d;

  assign fn      = aux_code[4:0];
  assign code_ok = aux_wr && (aux_code[6:5] == 2'b00);
  assign feoi_p  = code_ok && (fn == FN_FEOI);
  assign nbaf_p  = code_ok && (fn == FN_NBAF);

  always_comb begin
    t1_short_d = t1_short;
    if (code_ok && (fn == FN_T1SEL)) t1_short_d = aux_code[7];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) t1_short <= 1'b0;
    else        t1_short <= t1_short_d;
  end
endmodule

// File: rtl/srchs_t1_timer.sv
module srchs_t1_timer #(
  parameter int T1_LONG  = 11,
  parameter int T1_SHORT = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  input  logic short_sel,
  output logic done
);
  localparam int CW = $clog2(T1_LONG + 1);
  localparam logic [CW-1:0] LIM_L = CW'(T1_LONG - 1);
  localparam logic [CW-1:0] LIM_S = CW'(T1_SHORT - 1);

  logic [CW-1:0] cnt, cnt_d, lim;

  assign lim  = short_sel ? LIM_S : LIM_L;
  assign done = (cnt >= lim);

  always_comb begin
    cnt_d = cnt;
    if (clr)               cnt_d = '0;
    else if (run && !done) cnt_d = cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_d;
  end

  // R3: the count never passes the longer limit
  a_r3_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LIM_L);
endmodule

// File: rtl/srchs_engine.sv
module srchs_engine
  import srchs_pkg::*;
#(
  parameter int DW       = 8,
  parameter int T1_LONG  = 11,
  parameter int T1_SHORT = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          src_active,
  input  logic          ctl_atn,
  input  logic          bus_atn,
  input  logic          nrfd_in,
  input  logic          ndac_in,
  input  logic          dout_wr,
  input  logic [DW-1:0] dout_data,
  input  logic          aux_wr,
  input  logic [7:0]    aux_code,
  output logic [DW-1:0] dio_out,
  output logic          dav_out,
  output logic          eoi_out,
  output logic          bo_empty,
  output logic          hs_err
);
  sh_state_e     state_q, state_d;
  logic          pending_q, pending_d;
  logic          empty_d;
  logic          eoi_pend_q, eoi_pend_d;
  logic          err_d;
  logic          src_q;
  logic [DW-1:0] dbuf_q, dbuf_d, dio_d;
  logic          t1_short, feoi_p, nbaf_p, t1_done;
  logic          send_ok, accept, tm_clr, complete, abort, cancel;

  srchs_aux_decode u_aux (
    .clk(clk), .rst_n(rst_n), .aux_wr(aux_wr), .aux_code(aux_code),
    .t1_short(t1_short), .feoi_p(feoi_p), .nbaf_p(nbaf_p)
  );

  srchs_t1_timer #(.T1_LONG(T1_LONG), .T1_SHORT(T1_SHORT)) u_t1 (
    .clk(clk), .rst_n(rst_n), .clr(tm_clr), .run(state_q == SH_SETTLE),
    .short_sel(t1_short), .done(t1_done)
  );

  assign send_ok = ctl_atn || !bus_atn;
  assign accept  = dout_wr && !pending_q;
  assign cancel  = nbaf_p && pending_q && (state_q == SH_IDLE);

  // next-state logic
  always_comb begin
    state_d  = state_q;
    tm_clr   = 1'b0;
    complete = 1'b0;
    abort    = 1'b0;
    unique case (state_q)
      SH_IDLE: begin
        if (pending_q && send_ok && src_active && !cancel) begin
          state_d = SH_SETTLE;
          tm_clr  = 1'b1;
        end
      end
      SH_SETTLE: begin
        if (!send_ok) begin
          state_d = SH_IDLE;
        end else if (t1_done) begin
          if (!nrfd_in && !ndac_in) begin
            state_d = SH_IDLE;
            abort   = 1'b1;
          end else if (!nrfd_in) begin
            state_d = SH_VALID;
          end
        end
      end
      SH_VALID: begin
        if (!ndac_in) begin
          state_d  = SH_RELEASE;
          complete = 1'b1;
        end
      end
      SH_RELEASE: begin
        if (ndac_in) state_d = SH_IDLE;
      end
      default: state_d = SH_IDLE;
    endcase
  end

  // datapath next values
  always_comb begin
    pending_d  = pending_q;
    dbuf_d     = dbuf_q;
    dio_d      = dio_out;
    empty_d    = bo_empty;
    eoi_pend_d = eoi_pend_q;
    err_d      = abort;
    if (accept) begin
      pending_d = 1'b1;
      dbuf_d    = dout_data;
    end
    if (complete || abort || cancel) pending_d = 1'b0;
    if (tm_clr) dio_d = dbuf_q;
    if (complete || abort || cancel || (src_active && !src_q)) empty_d = 1'b1;
    if (accept) empty_d = 1'b0;
    if (complete) eoi_pend_d = 1'b0;
    if (feoi_p)   eoi_pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= SH_IDLE;
      pending_q  <= 1'b0;
      dbuf_q     <= '0;
      dio_out    <= '0;
      bo_empty   <= 1'b0;
      eoi_pend_q <= 1'b0;
      hs_err     <= 1'b0;
      src_q      <= 1'b0;
    end else begin
      state_q    <= state_d;
      pending_q  <= pending_d;
      dbuf_q     <= dbuf_d;
      dio_out    <= dio_d;
      bo_empty   <= empty_d;
      eoi_pend_q <= eoi_pend_d;
      hs_err     <= err_d;
      src_q      <= src_active;
    end
  end

  assign dav_out = (state_q == SH_VALID);
  assign eoi_out = eoi_pend_q && ((state_q == SH_SETTLE) || (state_q == SH_VALID));

  // R3: strobe only after the settling timer has expired
  a_r3_t1_before_dav: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dav_out) |-> $past(t1_done));
  // R4: data lines frozen while the strobe is up
  a_r4_dio_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (dav_out && $past(dav_out)) |-> $stable(dio_out));
  // R5: strobe only when the acceptors were ready
  a_r5_rfd_seen: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dav_out) |-> !$past(nrfd_in));
  // R6: strobe released right after data accepted
  a_r6_release: assert property (@(posedge clk) disable iff (!rst_n)
    (dav_out && !ndac_in) |=> !dav_out);
  // R2: accepted write empties the flag
  a_r2_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_wr && !pending_q) |=> !bo_empty);
  // R10: error pulse never coincides with a strobe
  a_r10_err_no_dav: assert property (@(posedge clk) disable iff (!rst_n)
    hs_err |-> !dav_out);
endmodule

// File: tb/test_srchs_engine.sv
module test_srchs_engine;
  localparam int T1L = 11;
  localparam int T1S = 6;

  logic clk = 1'b0;
  logic rst_n, src_active, ctl_atn, bus_atn, nrfd_in, ndac_in;
  logic dout_wr, aux_wr;
  logic [7:0] dout_data, aux_code, dio_out;
  logic dav_out, eoi_out, bo_empty, hs_err;

  int total = 0;
  int bad = 0;
  bit acc_absent = 1'b0, acc_hold = 1'b0;
  int acc_drop = 1, acc_rearm = 1;

  always #5 clk = ~clk;

  srchs_engine i_srchs_engine (
    .clk(clk), .rst_n(rst_n), .src_active(src_active), .ctl_atn(ctl_atn),
    .bus_atn(bus_atn), .nrfd_in(nrfd_in), .ndac_in(ndac_in),
    .dout_wr(dout_wr), .dout_data(dout_data), .aux_wr(aux_wr),
    .aux_code(aux_code), .dio_out(dio_out), .dav_out(dav_out),
    .eoi_out(eoi_out), .bo_empty(bo_empty), .hs_err(hs_err)
  );

  // acceptor model, acts 2 ns after each falling edge
  initial begin
    nrfd_in = 1'b0;
    ndac_in = 1'b1;
    forever begin
      @(negedge clk); #2;
      if (acc_absent) begin
        nrfd_in = 1'b0; ndac_in = 1'b0;
      end else begin
        nrfd_in = acc_hold;
        if (!dav_out) ndac_in = 1'b1;
        else if (ndac_in) begin
          repeat (acc_drop) @(negedge clk);
          #2 ndac_in = 1'b0;
          while (dav_out) @(negedge clk);
          repeat (acc_rearm) @(negedge clk);
          #2 ndac_in = 1'b1;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int lat(input bit short_t1);
    return (short_t1 ? T1S : T1L) + 1;
  endfunction

  task automatic wr(input logic [7:0] b);
    dout_wr = 1'b1; dout_data = b;
    @(negedge clk);
    dout_wr = 1'b0;
  endtask

  task automatic aux(input logic [7:0] c);
    aux_wr = 1'b1; aux_code = c;
    @(negedge clk);
    aux_wr = 1'b0;
  endtask

  task automatic meas(output int n);
    n = 0;
    while (!dav_out && n < 300) begin @(negedge clk); n++; end
  endtask

  // waits for the strobe to drop; checks data hold and the empty flag
  task automatic finish(input logic [7:0] b, input string rq);
    bit stable = 1'b1;
    while (dav_out) begin
      if (dio_out !== b) stable = 1'b0;
      @(negedge clk);
    end
    chk(stable, "R4 dio held during dav", int'(stable), 1);
    chk(bo_empty === 1'b1, rq, int'(bo_empty), 1);
  endtask

  task automatic settle_idle();
    repeat (acc_rearm + acc_drop + 4) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    total++; bad++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n;
    bit sh, fe, ok;
    logic [7:0] b;
    void'($urandom(32'd4242));
    rst_n = 1'b0; src_active = 1'b0; ctl_atn = 1'b0; bus_atn = 1'b0;
    dout_wr = 1'b0; dout_data = '0; aux_wr = 1'b0; aux_code = '0;
    repeat (3) @(negedge clk);
    chk(!dav_out && !eoi_out && !bo_empty && !hs_err, "R1 reset state",
        int'({dav_out, eoi_out, bo_empty, hs_err}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    src_active = 1'b1;
    @(negedge clk);
    chk(bo_empty === 1'b1, "R1 empty on talk entry", int'(bo_empty), 1);

    // basic transfer, long T1
    wr(8'hA5);
    chk(bo_empty === 1'b0, "R2 write clears empty", int'(bo_empty), 0);
    meas(n);
    chk(n == lat(0), "R3 long T1 latency", n, lat(0));
    chk(dio_out === 8'hA5, "R4 dio at dav", int'(dio_out), 8'hA5);
    chk(eoi_out === 1'b0, "R7 no eoi without command", int'(eoi_out), 0);
    finish(8'hA5, "R1 empty after transfer");
    settle_idle();

    // short T1
    aux(8'h95);
    wr(8'h3C); meas(n);
    chk(n == lat(1), "R3 short T1 latency", n, lat(1));
    finish(8'h3C, "R1 empty after transfer");
    settle_idle();
    aux(8'h15); aux(8'hB5);   // second code has bits 6:5 set: ignored
    wr(8'h4D); meas(n);
    chk(n == lat(0), "R3 code with bits 6:5 ignored", n, lat(0));
    finish(8'h4D, "R1 empty after transfer");
    settle_idle();

    // forced EOI one-shot
    aux(8'h08);
    wr(8'h0D); meas(n);
    chk(eoi_out === 1'b1, "R7 eoi with next byte", int'(eoi_out), 1);
    finish(8'h0D, "R1 empty after transfer");
    settle_idle();
    wr(8'h0A); meas(n);
    chk(eoi_out === 1'b0, "R7 eoi off on following byte", int'(eoi_out), 0);
    finish(8'h0A, "R1 empty after transfer");
    settle_idle();

    // NRFD held true
    acc_hold = 1'b1;
    repeat (2) @(negedge clk);
    wr(8'h21);
    ok = 1'b1;
    repeat (30) begin if (dav_out) ok = 1'b0; @(negedge clk); end
    chk(ok, "R5 no dav while nrfd true", int'(ok), 1);
    acc_hold = 1'b0;
    meas(n);
    chk(n <= 3, "R5 dav after nrfd release", n, 3);
    finish(8'h21, "R1 empty after transfer");
    settle_idle();

    // foreign ATN stall
    bus_atn = 1'b1;
    wr(8'h5A);
    ok = 1'b1;
    repeat (30) begin if (dav_out) ok = 1'b0; @(negedge clk); end
    chk(ok, "R8 byte held under foreign atn", int'(ok), 1);
    bus_atn = 1'b0;
    meas(n);
    chk(n == lat(0), "R8 sent after atn release", n, lat(0));
    chk(dio_out === 8'h5A, "R8 stalled byte value", int'(dio_out), 8'h5A);
    finish(8'h5A, "R1 empty after transfer");
    settle_idle();

    // ATN during T1 restarts the settling time
    wr(8'h11);
    repeat (4) @(negedge clk);
    bus_atn = 1'b1;
    repeat (5) @(negedge clk);
    chk(dav_out === 1'b0, "R8 no dav while atn", int'(dav_out), 0);
    bus_atn = 1'b0;
    meas(n);
    chk(n == lat(0), "R8 T1 restarts", n, lat(0));
    finish(8'h11, "R1 empty after transfer");
    settle_idle();

    // commands with own ATN
    ctl_atn = 1'b1; bus_atn = 1'b1;
    wr(8'hC3); meas(n);
    chk(n == lat(0), "R8 command sent with own atn", n, lat(0));
    finish(8'hC3, "R1 empty after transfer");
    settle_idle();
    ctl_atn = 1'b0; bus_atn = 1'b0;

    // write while pending is ignored
    bus_atn = 1'b1;
    wr(8'h01); wr(8'h02);
    bus_atn = 1'b0;
    meas(n);
    chk(dio_out === 8'h01, "R2 second write ignored", int'(dio_out), 8'h01);
    finish(8'h01, "R1 empty after transfer");
    settle_idle();

    // cancel stalled byte
    bus_atn = 1'b1;
    wr(8'h77);
    chk(bo_empty === 1'b0, "R2 write clears empty", int'(bo_empty), 0);
    aux(8'h05);
    chk(bo_empty === 1'b1, "R9 cancel sets empty", int'(bo_empty), 1);
    bus_atn = 1'b0;
    ok = 1'b1;
    repeat (30) begin if (dav_out) ok = 1'b0; @(negedge clk); end
    chk(ok, "R9 cancelled byte not sent", int'(ok), 1);

    // no acceptor
    acc_absent = 1'b1;
    repeat (3) @(negedge clk);
    wr(8'h99);
    n = 0; ok = 1'b1;
    while (!hs_err && n < 100) begin if (dav_out) ok = 1'b0; @(negedge clk); n++; end
    chk(n == lat(0), "R10 error at end of T1", n, lat(0));
    chk(ok && !dav_out, "R10 no dav on abort", int'(ok), 1);
    chk(bo_empty === 1'b1, "R10 empty after abort", int'(bo_empty), 1);
    @(negedge clk);
    chk(hs_err === 1'b0, "R10 error is one cycle", int'(hs_err), 0);
    acc_absent = 1'b0;
    repeat (4) @(negedge clk);

    // slow NDAC rearm delays the next byte
    acc_rearm = 25;
    wr(8'h66); meas(n);
    finish(8'h66, "R1 empty after transfer");
    wr(8'h67); meas(n);
    chk(n >= 20, "R6 next byte waits for ndac", n, 20);
    finish(8'h67, "R1 empty after transfer");
    acc_rearm = 1;
    settle_idle();

    // random transfers
    for (int i = 0; i < 40; i++) begin
      sh = 1'($urandom_range(0, 1));
      fe = 1'($urandom_range(0, 1));
      b  = 8'($urandom_range(0, 255));
      acc_drop  = $urandom_range(0, 5);
      acc_rearm = $urandom_range(0, 3);
      aux(sh ? 8'h95 : 8'h15);
      if (fe) aux(8'h08);
      wr(b); meas(n);
      chk(n == lat(sh), "R3 random latency", n, lat(sh));
      chk(dio_out === b, "R4 random byte", int'(dio_out), int'(b));
      chk(eoi_out === fe, "R7 random eoi", int'(eoi_out), int'(fe));
      finish(b, "R1 empty after transfer");
      settle_idle();
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule